// File: doc/BRIEF.md
# Addressable-Tap Serial Delay Line

This block is a one-bit serial delay line assembled from 32-stage segments wired end to end. On every active clock edge where the shift enable is high, a new bit enters stage 0 and every stored bit moves one stage further along. A binary tap select picks the stage whose content drives the tap output. The delay seen at the tap can therefore be fixed by tying the select to a constant, or changed while the line runs.

Each segment also drives its own final stage on a cascade output, so a designer can pick off fixed 32-stage delays or feed them into further logic. A parameter can add an output flip-flop behind the tap multiplexer. That flip-flop shares the clock and the shift enable, so it acts as one more stage of the line. A second parameter can register the cascade outputs in the same way. A third parameter chooses whether the line moves on the rising or the falling clock edge.

The storage deliberately has no reset. The reset input only switches off the built-in checks while it is asserted.

Top module: `tap_shift_chain`

## Requirements
- R1: On an active edge with `shift_en` high, stage 0 takes `din` and every stage k>0 takes the old value of stage k-1; stage 32 takes the old value of stage 31, so the segments form one continuous line.
- R2: On an active edge with `shift_en` low, no stage, tap register or cascade register changes.
- R3: With `OUT_REG`=0, `tap_out` shows stage `tap_sel` at once. Stage s holds the bit that was shifted in s+1 enabled edges ago, so the delay is `tap_sel`+1.
- R4: A `tap_sel` value of `TOTAL_LEN` or more selects stage `TOTAL_LEN`-1.
- R5: With `CASC_REG`=0, `casc_out[i]` always shows stage 32*i+31, the last stage of segment i.
- R6: With `OUT_REG`=1, `tap_out` comes from a flip-flop. On each enabled edge this flip-flop loads the stage that is selected before the edge, and it holds its value otherwise. The delay is therefore `tap_sel`+2, which means that a total length N needs `tap_sel`=N-2 (the N-1th stage).
- R7: With `EDGE`=EDGE_FALL, all storage updates on the falling clock edge. With EDGE_RISE, which is the default, it updates on the rising edge.
- R8: `rst` has no effect on the stages, the tap register or the cascade registers. Shifting continues while `rst` is high.
- R9: With `CASC_REG`=1, `casc_out[i]` is a flip-flop. On each enabled edge it loads the value that stage 32*i+31 holds before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the active edge is set by `EDGE` |
| rst | input | 1 | Synchronous active-high reset; turns off the checks only, storage ignores it |
| shift_en | input | 1 | Shift enable; also gates the optional output registers |
| din | input | 1 | Serial data into stage 0 |
| tap_sel | input | SEL_W | Stage index driven to the tap; SEL_W = clog2(32 * number of segments) |
| tap_out | output | 1 | Selected stage, direct or registered |
| casc_out | output | NSEG | Last stage of each segment, direct or registered |

## Verification
A shift and a change of tap select can happen on the same edge. The bench changes `tap_sel` on almost every cycle while shifting, and it sweeps the whole select range, including the values above the clamp limit. A behavioural queue model then judges the tap: for a direct tap it uses the new select against the contents after the shift, and for a registered tap it uses the select that was present before the edge. Reset is also held high during a burst of shifts, and the model simply ignores it. Two instances run at the same time: one is direct and uses the rising edge, the other is registered and uses the falling edge. Each instance is checked just after its own active edge.

// File: rtl/tapreg_pkg.sv
package tapreg_pkg;

    localparam int SEG_STAGES = 32;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    function automatic int seg_count(input int len);
        return (len + SEG_STAGES - 1) / SEG_STAGES;
    endfunction

    function automatic int sel_width(input int len);
        return $clog2(seg_count(len) * SEG_STAGES);
    endfunction

endpackage

// File: rtl/srl_seg.sv
module srl_seg
    import tapreg_pkg::*;
#(
    parameter int STAGES = SEG_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              din,
    output logic [STAGES-1:0] stg_o,
    output logic              last_o
);

    logic [STAGES-1:0] stg;

    // no reset on storage by design
    always_ff @(posedge clk) begin
        if (shift_en)
            stg <= {stg[STAGES-2:0], din};
    end

    assign stg_o  = stg;
    assign last_o = stg[STAGES-1];

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stg[0] == $past(din)); // R1
    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stg[STAGES-1:1] == $past(stg[STAGES-2:0])); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stg)); // R2

endmodule

// File: rtl/tap_select.sv
module tap_select
    import tapreg_pkg::*;
#(
    parameter int NSTG = 64,
    parameter int LEN  = 64,
    parameter int AW   = 6
) (
    input  logic [NSTG-1:0] stages,
    input  logic [AW-1:0]   sel,
    output logic            bit_o
);

    localparam int LAST = LEN - 1;

    logic [AW-1:0] idx;

    always_comb begin
        if (int'(sel) > LAST)
            idx = AW'(LAST);
        else
            idx = sel;
        bit_o = stages[idx];
    end

endmodule

// File: rtl/tap_shift_chain.sv
module tap_shift_chain
    import tapreg_pkg::*;
#(
    parameter int    TOTAL_LEN = 72,
    parameter bit    OUT_REG   = 1'b0,
    parameter bit    CASC_REG  = 1'b0,
    parameter edge_e EDGE      = EDGE_RISE,
    localparam int   NSEG      = seg_count(TOTAL_LEN),
    localparam int   SEL_W     = sel_width(TOTAL_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap_out,
    output logic [NSEG-1:0]  casc_out
);

    localparam int NSTG = NSEG * SEG_STAGES;

    logic                  clk_act;
    logic [SEG_STAGES-1:0] seg_stg [NSEG];
    logic [NSEG-1:0]       seg_in;
    logic [NSEG-1:0]       seg_last;
    logic [NSTG-1:0]       all_stg;
    logic                  sel_bit;

    generate
        if (EDGE == EDGE_FALL) begin : g_fall
            assign clk_act = ~clk;
        end else begin : g_rise
            assign clk_act = clk;
        end
    endgenerate

    assign seg_in[0] = din;

    generate
        for (genvar i = 0; i < NSEG; i++) begin : g_seg
            if (i > 0) begin : g_link
                assign seg_in[i] = seg_last[i-1];
                AST_CHAIN_LINK: assert property (@(posedge clk_act) disable iff (rst)
                    shift_en |=> seg_stg[i][0] == $past(seg_last[i-1])); // R1
            end
            srl_seg #(.STAGES(SEG_STAGES)) u_seg (
                .clk      (clk_act),
                .rst      (rst),
                .shift_en (shift_en),
                .din      (seg_in[i]),
                .stg_o    (seg_stg[i]),
                .last_o   (seg_last[i])
            );
            assign all_stg[i*SEG_STAGES +: SEG_STAGES] = seg_stg[i];
        end
    endgenerate

    tap_select #(.NSTG(NSTG), .LEN(TOTAL_LEN), .AW(SEL_W)) u_tap (
        .stages (all_stg),
        .sel    (tap_sel),
        .bit_o  (sel_bit)
    );

    generate
        if (OUT_REG) begin : g_out_ff
            logic tap_q;
            always_ff @(posedge clk_act) begin
                if (shift_en)
                    tap_q <= sel_bit;
            end
            assign tap_out = tap_q;
            AST_OUT_LOAD: assert property (@(posedge clk_act) disable iff (rst)
                shift_en |=> tap_out == $past(sel_bit)); // R6
            AST_OUT_HOLD: assert property (@(posedge clk_act) disable iff (rst)
                !shift_en |=> $stable(tap_out)); // R2
        end else begin : g_out_comb
            assign tap_out = sel_bit;
            AST_TAP_CLAMP: assert property (@(posedge clk_act) disable iff (rst)
                (int'(tap_sel) >= TOTAL_LEN) |-> tap_out == all_stg[TOTAL_LEN-1]); // R4
        end
    endgenerate

    generate
        if (CASC_REG) begin : g_casc_ff
            logic [NSEG-1:0] casc_q;
            always_ff @(posedge clk_act) begin
                if (shift_en)
                    casc_q <= seg_last;
            end
            assign casc_out = casc_q;
            AST_CASC_LOAD: assert property (@(posedge clk_act) disable iff (rst)
                shift_en |=> casc_out == $past(seg_last)); // R9
            AST_CASC_HOLD: assert property (@(posedge clk_act) disable iff (rst)
                !shift_en |=> $stable(casc_out)); // R2
        end else begin : g_casc_comb
            assign casc_out = seg_last;
            if (!OUT_REG && TOTAL_LEN >= SEG_STAGES) begin : g_tap_vs_casc
                AST_TAP_MEETS_CASC: assert property (@(posedge clk_act) disable iff (rst)
                    (tap_sel == SEL_W'(SEG_STAGES-1)) |-> tap_out == casc_out[0]); // R5
            end
        end
    endgenerate

endmodule

// File: tb/tap_shift_chain_test.sv
`timescale 1ns/100ps
module tap_shift_chain_test;
    import tapreg_pkg::*;

    localparam int LEN_A = 72;
    localparam int LEN_B = 40;
    localparam int NSA = 3;
    localparam int NSB = 2;
    localparam int QMAX = 140;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic din = 1'b0;
    logic [6:0] sel_a = '0;
    logic [5:0] sel_b = '0;
    logic tap_a, tap_b;
    logic [NSA-1:0] casc_a;
    logic [NSB-1:0] casc_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    bit q_a[$];
    bit q_b[$];
    bit expb_tap;
    bit expb_known = 1'b0;

    always #2 clk = ~clk;

    tap_shift_chain #(.TOTAL_LEN(LEN_A)) uut (
        .clk(clk), .rst(rst), .shift_en(en), .din(din),
        .tap_sel(sel_a), .tap_out(tap_a), .casc_out(casc_a)
    );

    tap_shift_chain #(.TOTAL_LEN(LEN_B), .OUT_REG(1'b1), .CASC_REG(1'b1),
                      .EDGE(EDGE_FALL)) uut_f (
        .clk(clk), .rst(rst), .shift_en(en), .din(din),
        .tap_sel(sel_b), .tap_out(tap_b), .casc_out(casc_b)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampi(input int s, input int len);
        return (s >= len) ? len - 1 : s;
    endfunction

    // one cycle: inputs applied just after a rising edge
    task automatic cyc(input logic e, input logic d, input int sa, input int sb, input string tag);
        en = e; din = d;
        sel_a = 7'(sa); sel_b = 6'(sb);
        @(negedge clk);
        if (e) begin
            int ib = clampi(sb, LEN_B);
            expb_known = (q_b.size() > ib);
            if (expb_known) expb_tap = q_b[ib];
            q_b.push_front(d);
            if (q_b.size() > QMAX) void'(q_b.pop_back());
        end
        #1;
        if (expb_known) chk({tag, " R6 R7 tap(fall,reg)"}, tap_b, expb_tap);
        for (int i = 0; i < NSB; i++)
            if (q_b.size() > 32*i+32) chk("R9 R7 casc(fall,reg)", casc_b[i], q_b[32*i+32]);
        @(posedge clk);
        if (e) begin
            q_a.push_front(d);
            if (q_a.size() > QMAX) void'(q_a.pop_back());
        end
        #1;
        begin
            int ia = clampi(sa, LEN_A);
            if (q_a.size() > ia) chk({tag, " R3 tap(rise)"}, tap_a, q_a[ia]);
        end
        for (int i = 0; i < NSA; i++)
            if (q_a.size() > 32*i+31) chk("R5 R1 casc(rise)", casc_a[i], q_a[32*i+31]);
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 0, 0, "R2 reset");
        rst = 1'b0;
        // fill beyond both lengths with a fixed tap
        for (int k = 0; k < 110; k++) cyc(1'b1, next_bit(), 5, 3, "R1 fill");
        // sweep selects while shifting, some idle edges mixed in
        for (int k = 0; k < 260; k++)
            cyc((k % 3) != 2, next_bit(), k % 128, (k * 7) % 64, "R4 sweep");
        // idle: selects move, storage holds
        for (int k = 0; k < 24; k++) cyc(1'b0, next_bit(), (k * 5) % 128, k % 64, "R2 idle");
        // boundary selects
        cyc(1'b1, 1'b1, 71, 38, "R3 last");
        cyc(1'b1, 1'b0, 72, 39, "R4 edge");
        cyc(1'b1, 1'b1, 127, 63, "R4 max");
        cyc(1'b1, 1'b0, 31, 0, "R5 seg0end");
        cyc(1'b1, 1'b1, 0, 0, "R3 first");
        // reset held while shifting continues
        rst = 1'b1;
        for (int k = 0; k < 30; k++) cyc(1'b1, next_bit(), 40 + k, k, "R8 rst");
        rst = 1'b0;
        for (int k = 0; k < 80; k++) cyc(k[0], next_bit(), 100 - k, 60 - (k % 50), "R8 after");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule